// File: doc/BRIEF.md
# Legacy Display Aperture Decoder

This block sits on the host memory path of a display controller and routes each access into the legacy display region below 1 MB. A 2-bit window-select field picks where the banked frame-buffer window sits and how large it is. A separate enable bit opens a 256-byte control-register window at 0xB8000. Every accepted access goes to one of three targets: the frame-buffer path, the register window, or no target at all.

Frame-buffer accesses leave as a single strobe that carries a translated offset. The offset is one of two bank bases plus the low 15 bits of the masked address. Register-window accesses are split into byte beats, one beat per cycle. The only register content modelled is a status byte, which always reads zero. Reads that no target claims, and reads of the register window, are answered by the block itself. The configuration inputs are registered on every clock edge, so a change applies only to accesses sampled at later edges. When the host asserts both strobes in the same cycle, the write wins.

When the 32 KB window at 0xB8000 is selected, it shares its space with the register window. An overlap flag is raised in that case. Addresses in that window that are not register addresses still reach frame-buffer memory.

Top module: `legacy_aperture_decoder`

## Requirements
- R1: The frame-buffer window depends on the registered window-select value: 0 covers 0xA0000–0xBFFFF, 1 covers 0xA0000–0xAFFFF, 2 covers 0xB0000–0xB7FFF and 3 covers 0xB8000–0xBFFFF.
- R2: The frame-buffer offset is computed in three steps. The address is ANDed with 0xFFFF when the select value is 0 or 1, and with 0x7FFF when it is 2 or 3. Bit 15 of the result picks bank base 1 when set and bank base 0 when clear. The chosen base is then added to bits 14:0, and the sum wraps at the offset width.
- R3: While the register enable is set, addresses 0xB8000–0xB80FF go to the register window whatever the select value, ahead of the frame-buffer window.
- R4: While the register enable is clear, addresses 0xB8000–0xB80FF are decoded only by the frame-buffer window rule.
- R5: A register access of size code 0 (byte), 1 (word) or 2/3 (dword) produces 1, 2 or 4 register beats on consecutive cycles. The first beat appears one cycle after acceptance. The index starts at address bits 7:0 and rises by one per beat, wrapping from 0xFF to 0x00. Beat i carries write-data bits 8i+7:8i.
- R6: A register byte at index 0x40 reads 0x00, and every other register byte reads 0xFF. A register read returns the assembled bytes, lowest index in bits 7:0 and unused upper bytes zero, with the response valid in the cycle of the last beat.
- R7: A read that no target claims returns 0xFF, 0xFFFF or 0xFFFFFFFF for byte, word or dword, one cycle after acceptance. A write that no target claims raises no strobe and no response.
- R8: The overlap output is high exactly when the select value registered at the previous edge is 3. In that case, non-register addresses in 0xB8000–0xBFFFF go to the frame-buffer path.
- R9: Configuration inputs take effect one edge after they are sampled. An access sampled at the same edge as a configuration change is decoded with the previous configuration.
- R10: The busy output is high while register beats remain after the current one. Requests presented while busy is high are ignored.
- R11: After reset every strobe, busy, response valid and overlap is low. The configuration starts as select 0, register window disabled and both bank bases zero.
- R12: A frame-buffer access raises the frame-buffer strobe for one cycle, one cycle after acceptance, carrying the write flag, size code and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_win_sel | input | 2 | Frame-buffer window select |
| cfg_reg_en | input | 1 | Register window enable |
| cfg_bank0 | input | OFF_W | Bank base used when masked bit 15 is clear |
| cfg_bank1 | input | OFF_W | Bank base used when masked bit 15 is set |
| host_addr | input | ADDR_W | Host byte address |
| host_rd | input | 1 | Read request |
| host_wr | input | 1 | Write request |
| host_size | input | 2 | 0 byte, 1 word, 2 or 3 dword |
| host_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| host_busy | output | 1 | Register beats still pending; requests ignored |
| fb_stb | output | 1 | Frame-buffer access strobe |
| fb_we | output | 1 | Frame-buffer write flag |
| fb_size | output | 2 | Frame-buffer access size code |
| fb_offset | output | OFF_W | Translated frame-buffer offset |
| fb_wdata | output | 32 | Frame-buffer write data |
| reg_stb | output | 1 | Register beat strobe |
| reg_we | output | 1 | Register beat write flag |
| reg_idx | output | 8 | Register byte index |
| reg_wdata | output | 8 | Register beat write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| overlap | output | 1 | Register window overlaps the selected frame-buffer window |

## Verification
The assertions check several properties on every cycle. Frame-buffer and register strobes never overlap, and a busy cycle is always followed by a register beat with an index one higher. A frame-buffer strobe only follows an idle cycle, response bytes are only 0x00 or 0xFF, and the overlap flag tracks the previously sampled select value. The decode itself can only be shown by the bench's scenarios. That covers window ranges and their edges, bank translation, the precedence of the register window, all-ones widths, status-byte assembly, index wrap, and the one-edge delay on configuration changes.

// File: rtl/lad_pkg.sv
package lad_pkg;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_FB   = 2'd1,
        TGT_REG  = 2'd2
    } lad_tgt_e;

    localparam int unsigned WIN_BASE_HI = 12'hB80;

    function automatic logic [2:0] size_beats(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [31:0] size_ones(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/lad_window_decode.sv
module lad_window_decode
    import lad_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        win_sel,
    input  logic              reg_en,
    output lad_tgt_e          tgt,
    output logic [15:0]       mask
);
    logic hi_zero;
    logic in_reg;
    logic in_fb;

    generate
        if (ADDR_W > 20) begin : g_wide
            assign hi_zero = ~|addr[ADDR_W-1:20];
        end else begin : g_narrow
            assign hi_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        in_reg = reg_en && hi_zero && (addr[19:8] == 12'(WIN_BASE_HI));
        case (win_sel)
            2'd0:    in_fb = (addr[19:17] == 3'b101);
            2'd1:    in_fb = (addr[19:16] == 4'hA);
            2'd2:    in_fb = (addr[19:15] == 5'b10110);
            default: in_fb = (addr[19:15] == 5'b10111);
        endcase
        in_fb = in_fb && hi_zero;
        mask  = win_sel[1] ? 16'h7FFF : 16'hFFFF;
        if (in_reg) begin
            tgt = TGT_REG;
        end else if (in_fb) begin
            tgt = TGT_FB;
        end else begin
            tgt = TGT_NONE;
        end
    end

endmodule

// File: rtl/lad_bank_xlate.sv
module lad_bank_xlate #(
    parameter int OFF_W = 22
) (
    input  logic [15:0]      addr_lo,
    input  logic [15:0]      mask,
    input  logic [OFF_W-1:0] base0,
    input  logic [OFF_W-1:0] base1,
    output logic [OFF_W-1:0] offset
);
    logic [15:0]      masked;
    logic [OFF_W-1:0] base_sel;

    always_comb begin
        masked   = addr_lo & mask;
        base_sel = masked[15] ? base1 : base0;
        offset   = base_sel + OFF_W'(masked[14:0]);
    end

endmodule

// File: rtl/lad_reg_sequencer.sv
module lad_reg_sequencer
    import lad_pkg::*;
#(
    parameter logic [7:0] STATUS_IDX = 8'h40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  start_idx,
    input  logic        start_we,
    input  logic [1:0]  start_size,
    input  logic [31:0] start_wdata,
    output logic        busy,
    output logic        stb,
    output logic        we,
    output logic [7:0]  idx,
    output logic [7:0]  wbyte,
    output logic        rsp_valid,
    output logic [31:0] rsp_data
);
    typedef struct packed {
        logic        stb;
        logic        we;
        logic [7:0]  idx;
        logic [1:0]  left;
        logic [1:0]  pos;
        logic [31:0] wdata;
        logic [31:0] acc;
        logic        rsp;
    } seq_t;

    seq_t seq_d, seq_q;

    function automatic logic [7:0] rd_byte(input logic [7:0] i);
        return (i == STATUS_IDX) ? 8'h00 : 8'hFF;
    endfunction

    always_comb begin
        logic [2:0] nb;
        logic [7:0] nidx;
        logic [1:0] npos;
        seq_d     = seq_q;
        seq_d.stb = 1'b0;
        seq_d.rsp = 1'b0;
        nb        = size_beats(start_size);
        nidx      = seq_q.idx + 8'd1;
        npos      = seq_q.pos + 2'd1;
        if (seq_q.left != 2'd0) begin
            seq_d.stb  = 1'b1;
            seq_d.idx  = nidx;
            seq_d.pos  = npos;
            seq_d.left = seq_q.left - 2'd1;
            seq_d.acc  = seq_q.acc | (32'(rd_byte(nidx)) << {npos, 3'b000});
            seq_d.rsp  = !seq_q.we && (seq_q.left == 2'd1);
        end else if (start) begin
            seq_d.stb   = 1'b1;
            seq_d.we    = start_we;
            seq_d.idx   = start_idx;
            seq_d.pos   = 2'd0;
            seq_d.left  = 2'(nb - 3'd1);
            seq_d.wdata = start_wdata;
            seq_d.acc   = 32'(rd_byte(start_idx));
            seq_d.rsp   = !start_we && (nb == 3'd1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = (seq_q.left != 2'd0);
    assign stb       = seq_q.stb;
    assign we        = seq_q.we;
    assign idx       = seq_q.idx;
    assign wbyte     = 8'(seq_q.wdata >> {seq_q.pos, 3'b000});
    assign rsp_valid = seq_q.rsp;
    assign rsp_data  = seq_q.acc;

endmodule

// File: rtl/legacy_aperture_decoder.sv
module legacy_aperture_decoder
    import lad_pkg::*;
#(
    parameter int         ADDR_W     = 20,
    parameter int         OFF_W      = 22,
    parameter logic [7:0] STATUS_IDX = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_win_sel,
    input  logic              cfg_reg_en,
    input  logic [OFF_W-1:0]  cfg_bank0,
    input  logic [OFF_W-1:0]  cfg_bank1,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [1:0]        host_size,
    input  logic [31:0]       host_wdata,
    output logic              host_busy,
    output logic              fb_stb,
    output logic              fb_we,
    output logic [1:0]        fb_size,
    output logic [OFF_W-1:0]  fb_offset,
    output logic [31:0]       fb_wdata,
    output logic              reg_stb,
    output logic              reg_we,
    output logic [7:0]        reg_idx,
    output logic [7:0]        reg_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              overlap
);
    typedef struct packed {
        logic [1:0]       sel;
        logic             ren;
        logic [OFF_W-1:0] b0;
        logic [OFF_W-1:0] b1;
        logic             ovl;
        logic             fstb;
        logic             fwe;
        logic [1:0]       fsize;
        logic [OFF_W-1:0] foff;
        logic [31:0]      fwdata;
        logic             nrsp;
        logic [31:0]      ndata;
    } top_t;

    top_t top_d, top_q;

    lad_tgt_e         tgt;
    logic [15:0]      win_mask;
    logic [OFF_W-1:0] xlate_off;
    logic             seq_busy;
    logic             seq_start;
    logic             seq_rsp;
    logic [31:0]      seq_data;
    logic             accept;

    lad_window_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr    (host_addr),
        .win_sel (top_q.sel),
        .reg_en  (top_q.ren),
        .tgt     (tgt),
        .mask    (win_mask)
    );

    lad_bank_xlate #(.OFF_W(OFF_W)) u_xlate (
        .addr_lo (host_addr[15:0]),
        .mask    (win_mask),
        .base0   (top_q.b0),
        .base1   (top_q.b1),
        .offset  (xlate_off)
    );

    assign accept    = (host_rd || host_wr) && !seq_busy;
    assign seq_start = accept && (tgt == TGT_REG);

    lad_reg_sequencer #(.STATUS_IDX(STATUS_IDX)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (seq_start),
        .start_idx   (host_addr[7:0]),
        .start_we    (host_wr),
        .start_size  (host_size),
        .start_wdata (host_wdata),
        .busy        (seq_busy),
        .stb         (reg_stb),
        .we          (reg_we),
        .idx         (reg_idx),
        .wbyte       (reg_wdata),
        .rsp_valid   (seq_rsp),
        .rsp_data    (seq_data)
    );

    always_comb begin
        top_d        = top_q;
        top_d.sel    = cfg_win_sel;
        top_d.ren    = cfg_reg_en;
        top_d.b0     = cfg_bank0;
        top_d.b1     = cfg_bank1;
        top_d.ovl    = (cfg_win_sel == 2'd3);
        top_d.fstb   = 1'b0;
        top_d.nrsp   = 1'b0;
        if (accept && (tgt == TGT_FB)) begin
            top_d.fstb   = 1'b1;
            top_d.fwe    = host_wr;
            top_d.fsize  = host_size;
            top_d.foff   = xlate_off;
            top_d.fwdata = host_wdata;
        end
        if (accept && (tgt == TGT_NONE) && !host_wr) begin
            top_d.nrsp  = 1'b1;
            top_d.ndata = size_ones(host_size);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign host_busy = seq_busy;
    assign fb_stb    = top_q.fstb;
    assign fb_we     = top_q.fwe;
    assign fb_size   = top_q.fsize;
    assign fb_offset = top_q.foff;
    assign fb_wdata  = top_q.fwdata;
    assign rsp_valid = top_q.nrsp || seq_rsp;
    assign rsp_data  = seq_rsp ? seq_data : top_q.ndata;
    assign overlap   = top_q.ovl;

endmodule

// File: rtl/lad_checks.sv
module lad_checks (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cfg_win_sel,
    input logic        host_busy,
    input logic        fb_stb,
    input logic        reg_stb,
    input logic [7:0]  reg_idx,
    input logic        rsp_valid,
    input logic [31:0] rsp_data,
    input logic        overlap
);
    // R10
    busy_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy |=> reg_stb);

    // R5
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_stb && host_busy) |=> (reg_idx == $past(reg_idx) + 8'd1));

    // R10
    excl_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fb_stb && reg_stb));

    // R12
    fb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fb_stb) |-> !$past(host_busy));

    // R7
    rsp_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_data[7:0] == 8'h00 || rsp_data[7:0] == 8'hFF) &&
                       (rsp_data[15:8] == 8'h00 || rsp_data[15:8] == 8'hFF) &&
                       (rsp_data[23:16] == 8'h00 || rsp_data[23:16] == 8'hFF) &&
                       (rsp_data[31:24] == 8'h00 || rsp_data[31:24] == 8'hFF)));

    // R8
    overlap_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (overlap == ($past(cfg_win_sel) == 2'd3)));

endmodule

bind legacy_aperture_decoder lad_checks chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_win_sel (cfg_win_sel),
    .host_busy   (host_busy),
    .fb_stb      (fb_stb),
    .reg_stb     (reg_stb),
    .reg_idx     (reg_idx),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .overlap     (overlap)
);

// File: tb/legacy_aperture_decoder_tb.sv
module legacy_aperture_decoder_tb_top;
    localparam int OFF_W = 22;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_win_sel = '0;
    logic              cfg_reg_en = 1'b0;
    logic [OFF_W-1:0]  cfg_bank0 = '0;
    logic [OFF_W-1:0]  cfg_bank1 = '0;
    logic [19:0]       host_addr = '0;
    logic              host_rd = 1'b0;
    logic              host_wr = 1'b0;
    logic [1:0]        host_size = '0;
    logic [31:0]       host_wdata = '0;
    logic              host_busy, fb_stb, fb_we, reg_stb, reg_we, rsp_valid, overlap;
    logic [1:0]        fb_size;
    logic [OFF_W-1:0]  fb_offset;
    logic [31:0]       fb_wdata, rsp_data;
    logic [7:0]        reg_idx, reg_wdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [1:0]       bsel = '0;
    bit               ben = 1'b0;
    logic [OFF_W-1:0] bb0 = '0;
    logic [OFF_W-1:0] bb1 = '0;

    always #4 clk = ~clk;

    legacy_aperture_decoder #(.ADDR_W(20), .OFF_W(OFF_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_win_sel(cfg_win_sel), .cfg_reg_en(cfg_reg_en),
        .cfg_bank0(cfg_bank0), .cfg_bank1(cfg_bank1), .host_addr(host_addr),
        .host_rd(host_rd), .host_wr(host_wr), .host_size(host_size),
        .host_wdata(host_wdata), .host_busy(host_busy), .fb_stb(fb_stb),
        .fb_we(fb_we), .fb_size(fb_size), .fb_offset(fb_offset), .fb_wdata(fb_wdata),
        .reg_stb(reg_stb), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .overlap(overlap)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // 0 none, 1 frame buffer, 2 register window
    function automatic int exp_tgt(input logic [19:0] a);
        bit fb;
        if (ben && a[19:8] == 12'hB80) return 2;
        case (bsel)
            2'd0:    fb = (a >= 20'hA0000 && a <= 20'hBFFFF);
            2'd1:    fb = (a >= 20'hA0000 && a <= 20'hAFFFF);
            2'd2:    fb = (a >= 20'hB0000 && a <= 20'hB7FFF);
            default: fb = (a >= 20'hB8000 && a <= 20'hBFFFF);
        endcase
        return fb ? 1 : 0;
    endfunction

    function automatic logic [OFF_W-1:0] exp_off(input logic [19:0] a);
        logic [15:0] m;
        m = a[15:0] & ((bsel < 2) ? 16'hFFFF : 16'h7FFF);
        return (m[15] ? bb1 : bb0) + OFF_W'(m[14:0]);
    endfunction

    function automatic int nbeats(input logic [1:0] sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] ones(input logic [1:0] sz);
        return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    task automatic set_cfg(input logic [1:0] s, input bit e, input logic [OFF_W-1:0] b0,
                           input logic [OFF_W-1:0] b1);
        @(negedge clk);
        cfg_win_sel = s; cfg_reg_en = e; cfg_bank0 = b0; cfg_bank1 = b1;
        bsel = s; ben = e; bb0 = b0; bb1 = b1;
        @(negedge clk);
        chk(overlap == (s == 2'd3), "R8 overlap flag", 32'(overlap), 32'(s == 2'd3));
    endtask

    task automatic check_result(input logic [19:0] a, input bit rd, input logic [1:0] sz,
                                input logic [31:0] wd, input int t);
        int n;
        logic [31:0] acc;
        n = nbeats(sz);
        acc = '0;
        if (t == 1) begin
            chk(fb_stb == 1'b1, "R1 R12 fb strobe", 32'(fb_stb), 32'd1);
            chk(fb_offset == exp_off(a), "R2 fb offset", 32'(fb_offset), 32'(exp_off(a)));
            chk(fb_we == !rd && fb_size == sz, "R12 fb we/size",
                {fb_we, 2'b0, fb_size}, {!rd, 2'b0, sz});
            if (!rd) chk(fb_wdata == wd, "R12 fb wdata", fb_wdata, wd);
            chk(!reg_stb && !rsp_valid, "R3 R4 no other target", {reg_stb, rsp_valid}, 32'd0);
        end else if (t == 0) begin
            chk(!fb_stb && !reg_stb, "R7 unclaimed no strobe", {fb_stb, reg_stb}, 32'd0);
            chk(rsp_valid == rd, "R7 unclaimed rsp_valid", 32'(rsp_valid), 32'(rd));
            if (rd) chk(rsp_data == ones(sz), "R7 all-ones width", rsp_data, ones(sz));
        end else begin
            for (int i = 0; i < n; i++) begin
                logic [7:0] ei;
                ei = 8'(a[7:0] + 8'(i));
                acc = acc | (32'((ei == 8'h40) ? 8'h00 : 8'hFF) << (8 * i));
                chk(reg_stb && !fb_stb, "R3 R5 reg beat strobe", {fb_stb, reg_stb}, 32'd1);
                chk(reg_idx == ei, "R5 reg index", 32'(reg_idx), 32'(ei));
                chk(reg_we == !rd, "R5 reg we", 32'(reg_we), 32'(!rd));
                if (!rd) chk(reg_wdata == wd[8*i +: 8], "R5 reg byte lane",
                             32'(reg_wdata), 32'(wd[8*i +: 8]));
                chk(host_busy == (i < n - 1), "R10 busy", 32'(host_busy), 32'(i < n - 1));
                if (rd && i == n - 1) begin
                    chk(rsp_valid == 1'b1, "R6 reg rsp valid", 32'(rsp_valid), 32'd1);
                    chk(rsp_data == acc, "R6 reg read data", rsp_data, acc);
                end else begin
                    chk(rsp_valid == 1'b0, "R6 no early rsp", 32'(rsp_valid), 32'd0);
                end
                if (i < n - 1) @(negedge clk);
            end
        end
    endtask

    task automatic access(input logic [19:0] a, input bit rd, input logic [1:0] sz,
                          input logic [31:0] wd);
        int t;
        t = exp_tgt(a);
        @(negedge clk);
        host_addr = a; host_rd = rd; host_wr = !rd; host_size = sz; host_wdata = wd;
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        check_result(a, rd, sz, wd, t);
    endtask

    logic [19:0] edges [11] = '{20'h9FFFF, 20'hA0000, 20'hAFFFF, 20'hB0000, 20'hB7FFF,
                               20'hB8000, 20'hB8040, 20'hB80FF, 20'hB8100, 20'hBFFFF,
                               20'hC0000};

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R11
        chk(!fb_stb && !reg_stb && !rsp_valid && !host_busy && !overlap, "R11 reset outputs",
            {fb_stb, reg_stb, rsp_valid, host_busy, overlap}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset config is select 0, disabled, zero banks
        access(20'hB8040, 1'b0, 2'd0, 32'h11);
        access(20'hA1234, 1'b1, 2'd1, 32'h0);

        // R1 R2 R3 R4 R7 R8: every select, enable, size at window edges
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 2; e++) begin
                set_cfg(2'(s), bit'(e), 22'h01_0000 + 22'(s), 22'h20_0000 + 22'(e));
                for (int z = 0; z < 3; z++) begin
                    foreach (edges[k]) begin
                        access(edges[k], bit'((k + z) % 2), 2'(z), 32'hA1B2_C3D4 + 32'(k));
                    end
                end
            end
        end

        // R5 index wrap and status byte inside a dword read
        set_cfg(2'd1, 1'b1, 22'h0, 22'h0);
        access(20'hB80FE, 1'b1, 2'd2, 32'h0);
        access(20'hB803E, 1'b1, 2'd3, 32'h0);
        access(20'hB80FF, 1'b0, 2'd1, 32'h0000_BEEF);

        // R9: access sampled with a config change uses the old config
        set_cfg(2'd0, 1'b0, 22'h00_0100, 22'h00_0200);
        @(negedge clk);
        cfg_win_sel = 2'd2;
        host_addr = 20'hA0010; host_wr = 1'b1; host_size = 2'd0; host_wdata = 32'h5A;
        @(negedge clk);
        host_wr = 1'b0;
        chk(fb_stb == 1'b1, "R9 old config applied", 32'(fb_stb), 32'd1);
        chk(fb_offset == 22'h0110, "R9 old config offset", 32'(fb_offset), 32'h110);
        bsel = 2'd2;
        access(20'hA0010, 1'b1, 2'd0, 32'h0);

        // R10: request during busy is ignored
        set_cfg(2'd1, 1'b1, 22'h0, 22'h0);
        @(negedge clk);
        host_addr = 20'hB8010; host_wr = 1'b1; host_size = 2'd2; host_wdata = 32'h4433_2211;
        @(negedge clk);
        host_addr = 20'hA0000; host_wdata = 32'hFFFF_0000; host_size = 2'd0;
        chk(reg_stb && reg_idx == 8'h10, "R10 first beat", 32'(reg_idx), 32'h10);
        @(negedge clk);
        host_wr = 1'b0;
        chk(reg_idx == 8'h11 && reg_wdata == 8'h22, "R10 beat unaffected",
            {reg_idx, reg_wdata}, 32'h1122);
        @(negedge clk);
        @(negedge clk);
        chk(reg_idx == 8'h13 && !host_busy, "R10 last beat", {host_busy, reg_idx}, 32'h13);
        @(negedge clk);
        chk(!fb_stb && !reg_stb, "R10 ignored request", {fb_stb, reg_stb}, 32'd0);

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [19:0] a;
            if ($urandom_range(7) == 0)
                set_cfg(2'($urandom_range(3)), bit'($urandom_range(1)),
                        OFF_W'($urandom()), OFF_W'($urandom()));
            if ($urandom_range(2) == 0) a = edges[$urandom_range(10)];
            else a = 20'h98000 + 20'($urandom_range(20'h2FFFF));
            access(a, bit'($urandom_range(1)), 2'($urandom_range(3)), $urandom());
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule